// File: doc/BRIEF.md
# Reset-Time Strap Latch

This block takes a group of multiplexed configuration pins and samples them while the chip's external active-low reset pin is held low. When reset is released, it freezes the captured values. These values set the start-up contents of several control fields: a 5-bit PHY management address, the advertised speed/duplex abilities and the matching duplex control bit, the MAC data interface selection (MII or RMII), the LED behaviour, and the auto-MDIX enable. It also sets an isolate flag, which is raised only when the strapped address is zero. The pins serve other functions once reset is over. While reset is held, the block keeps their output drivers off, and it gives the pins back to those functions after the new configuration has been committed.

The reset pin and the strap pins pass through the same two-flop synchronizer, so they stay aligned in time. A small state machine, clocked at 25 MHz, measures how long reset stays low. It has three states. `ST_RUN` is normal operation. `ST_COUNT` counts a low pulse that is still too short. `ST_SAMPLE` means the pulse is long enough and the straps are being sampled. The transitions are:

- RUN→COUNT on the first low cycle.
- COUNT→SAMPLE when the low count reaches `MIN_LOW_CYC`.
- COUNT→RUN when reset rises early. This is a glitch, and it is discarded.
- SAMPLE→RUN when reset rises. This is the commit.

If `MIN_LOW_CYC` is 1, the machine goes straight from RUN to SAMPLE. A separate power-on reset loads the default values that undriven pins would give. Software may rewrite the address later, but the isolate flag follows only the committed strap address.

Top module: `strap_latch_top`

## Requirements
- R1: Strap values present while reset is low are committed when reset is released after a valid pulse. Strap changes after release have no effect on any configuration output.
- R2: A reset pin low pulse of at least `MIN_LOW_CYC` (25) clock cycles commits the straps. A pulse of 24 cycles or fewer leaves every configuration output unchanged.
- R3: After power-on reset, the outputs hold the undriven-pin defaults: address 1, all abilities advertised, full duplex 1, RMII 0, LED link-only 1, MDIX 1, isolate 0.
- R4: `isolate` is 1 exactly when the last committed strap address is 0. Software address writes never change it.
- R5: A software write (`sw_addr_we`) while the block is in normal operation loads `phy_addr` on the next cycle. A strap commit overrides `phy_addr` with the strapped address.
- R6: `adv_abil` bit order is {100 full, 100 half, 10 full, 10 half}. Advertisement strap 0 gives 4'b0101, and strap 1 gives 4'b1111. `ctl_full_duplex` equals the strap.
- R7: `rmii_mode` equals the committed interface strap: 0 selects MII and 1 selects RMII.
- R8: `led_link_only` and `mdix_en` equal their committed straps. 1 means link-only LED mode and MDIX enabled.
- R9: `strap_pin_oe` is 0 whenever the reset pin is low. It stays 0 while a pulse is being measured or sampled, and it returns to 1 within 4 cycles after release.
- R10: Software address writes made while the reset pin is low, including during a too-short pulse, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| por_n | input | 1 | Power-on reset, active low, loads defaults |
| rst_pin_n | input | 1 | External hardware reset pin, active low |
| pin_addr | input | 5 | Address strap pins |
| pin_an_sel | input | 1 | Advertisement strap (1 = half and full duplex) |
| pin_rmii_sel | input | 1 | Interface strap (1 = RMII) |
| pin_led_sel | input | 1 | LED strap (1 = link-only mode) |
| pin_mdix_sel | input | 1 | Auto-MDIX strap (1 = enabled) |
| sw_addr_we | input | 1 | Software address write strobe |
| sw_addr_wdata | input | 5 | Software address write value |
| strap_pin_oe | output | 1 | Output enable for the shared pins |
| phy_addr | output | 5 | Current management address |
| isolate | output | 1 | MII isolate flag |
| adv_abil | output | 4 | Advertised ability field |
| ctl_full_duplex | output | 1 | Initial duplex control bit |
| rmii_mode | output | 1 | Interface mode |
| led_link_only | output | 1 | LED mode |
| mdix_en | output | 1 | Auto-MDIX enable |

## Verification
The bench drives reset pulses of exactly 25 cycles and exactly 24 cycles. This separates a correct threshold from an off-by-one in the low-time counter. Several strap patterns are used: a non-zero address with every select inverted from its default, an all-zero address, and an all-ones address. These expose any swapped or stuck field in the ability and mode outputs. Software writes of a non-zero address after a zero strap, and of zero after a non-zero strap, show whether isolate follows the strap or the register. A write made during a short pulse shows whether writes are gated while reset is low.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int PHY_ADDR_W = 5;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_COUNT  = 2'd1,
        ST_SAMPLE = 2'd2
    } rst_state_e;

    typedef struct packed {
        logic [PHY_ADDR_W-1:0] addr;
        logic                  an_all;
        logic                  rmii;
        logic                  led_link_only;
        logic                  mdix;
    } strap_t;

    localparam int STRAP_W = $bits(strap_t);

    localparam strap_t STRAP_DEFAULT = '{
        addr:          5'd1,
        an_all:        1'b1,
        rmii:          1'b0,
        led_link_only: 1'b1,
        mdix:          1'b1
    };

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) chain_q <= RST_VAL;
                else        chain_q <= d;
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/strap_rst_fsm.sv
module strap_rst_fsm
    import strap_pkg::*;
#(
    parameter int MIN_LOW_CYC = 25
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_sync_n,
    output logic sample_en,
    output logic commit,
    output logic run_active,
    output logic pins_oe_q
);

    localparam int CNT_W = $clog2(MIN_LOW_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_LOW_CYC - 1);

    rst_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q   <= ST_RUN;
            cnt_q     <= '0;
            pins_oe_q <= 1'b1;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            pins_oe_q <= (state_d == ST_RUN) && rst_sync_n;
        end
    end

    // next state and low-time counter
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            ST_RUN: begin
                if (!rst_sync_n) begin
                    if (MIN_LOW_CYC <= 1) begin
                        state_d = ST_SAMPLE;
                    end else begin
                        state_d = ST_COUNT;
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            ST_COUNT: begin
                if (rst_sync_n) begin
                    state_d = ST_RUN;            // glitch, discard
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_SAMPLE;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_SAMPLE: begin
                if (rst_sync_n) state_d = ST_RUN; // commit
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        sample_en  = !rst_sync_n;
        commit     = (state_q == ST_SAMPLE) && rst_sync_n;
        run_active = (state_q == ST_RUN) && rst_sync_n;
    end

    AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_COUNT) |-> (cnt_q != '0 && cnt_q < CNT_W'(MIN_LOW_CYC))); // R2

    AST_PINS_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        (state_q != ST_RUN) |-> !pins_oe_q); // R9

    AST_COMMIT_ENDS_SAMPLE: assert property (@(posedge clk) disable iff (!por_n)
        commit |=> (state_q == ST_RUN)); // R1

endmodule

// File: rtl/strap_cfg_regs.sv
module strap_cfg_regs
    import strap_pkg::*;
(
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  sample_en,
    input  logic                  commit,
    input  logic                  run_active,
    input  strap_t                strap_in,
    input  logic                  wr_en,
    input  logic [PHY_ADDR_W-1:0] wr_addr,
    output strap_t                cfg,
    output logic [PHY_ADDR_W-1:0] phy_addr,
    output logic                  isolate,
    output logic [3:0]            adv_abil,
    output logic                  full_duplex
);

    strap_t                shadow_q;
    strap_t                cfg_q;
    logic [PHY_ADDR_W-1:0] addr_q;
    logic                  iso_q;

    // shadow follows the pins for as long as reset is low
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)         shadow_q <= STRAP_DEFAULT;
        else if (sample_en) shadow_q <= strap_in;
    end

    // committed configuration and isolate
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cfg_q <= STRAP_DEFAULT;
            iso_q <= 1'b0;
        end else if (commit) begin
            cfg_q <= shadow_q;
            iso_q <= (shadow_q.addr == '0);
        end
    end

    // software-visible address: strap commit has priority
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                     addr_q <= STRAP_DEFAULT.addr;
        else if (commit)                addr_q <= shadow_q.addr;
        else if (wr_en && run_active)   addr_q <= wr_addr;
    end

    // field decode: {100 FD, 100 HD, 10 FD, 10 HD}
    always_comb begin
        adv_abil    = {cfg_q.an_all, 1'b1, cfg_q.an_all, 1'b1};
        full_duplex = cfg_q.an_all;
    end

    assign cfg      = cfg_q;
    assign phy_addr = addr_q;
    assign isolate  = iso_q;

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!por_n)
        !commit |=> $stable(cfg_q)); // R2

    AST_ISO_STRAP_ONLY: assert property (@(posedge clk) disable iff (!por_n)
        !commit |=> $stable(iso_q)); // R4

    AST_ISO_ADDR_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        iso_q == (cfg_q.addr == '0)); // R4

    AST_WR_IGNORED_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        (!run_active && !commit) |=> $stable(addr_q)); // R10

endmodule

// File: rtl/strap_latch_top.sv
module strap_latch_top
    import strap_pkg::*;
#(
    parameter int MIN_LOW_CYC = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_pin_n,
    input  logic [4:0] pin_addr,
    input  logic       pin_an_sel,
    input  logic       pin_rmii_sel,
    input  logic       pin_led_sel,
    input  logic       pin_mdix_sel,
    input  logic       sw_addr_we,
    input  logic [4:0] sw_addr_wdata,
    output logic       strap_pin_oe,
    output logic [4:0] phy_addr,
    output logic       isolate,
    output logic [3:0] adv_abil,
    output logic       ctl_full_duplex,
    output logic       rmii_mode,
    output logic       led_link_only,
    output logic       mdix_en
);

    strap_t raw_straps;
    strap_t sync_straps;
    strap_t cfg;
    logic   rst_sync_n;
    logic   sample_en, commit, run_active, pins_oe_q;

    assign raw_straps = '{addr: pin_addr, an_all: pin_an_sel, rmii: pin_rmii_sel,
                          led_link_only: pin_led_sel, mdix: pin_mdix_sel};

    strap_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_rst_sync (
        .clk(clk), .por_n(por_n), .d(rst_pin_n), .q(rst_sync_n)
    );

    strap_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES), .RST_VAL(STRAP_DEFAULT)) i_pin_sync (
        .clk(clk), .por_n(por_n), .d(raw_straps), .q(sync_straps)
    );

    strap_rst_fsm #(.MIN_LOW_CYC(MIN_LOW_CYC)) i_fsm (
        .clk(clk), .por_n(por_n), .rst_sync_n(rst_sync_n),
        .sample_en(sample_en), .commit(commit),
        .run_active(run_active), .pins_oe_q(pins_oe_q)
    );

    strap_cfg_regs i_regs (
        .clk(clk), .por_n(por_n), .sample_en(sample_en), .commit(commit),
        .run_active(run_active), .strap_in(sync_straps),
        .wr_en(sw_addr_we), .wr_addr(sw_addr_wdata),
        .cfg(cfg), .phy_addr(phy_addr), .isolate(isolate),
        .adv_abil(adv_abil), .full_duplex(ctl_full_duplex)
    );

    // raw pin gates the enable at once; the registered term covers sampling
    assign strap_pin_oe  = rst_pin_n & pins_oe_q;
    assign rmii_mode     = cfg.rmii;
    assign led_link_only = cfg.led_link_only;
    assign mdix_en       = cfg.mdix;

    AST_OE_OFF_PIN_LOW: assert property (@(posedge clk) disable iff (!por_n)
        !rst_sync_n |-> !strap_pin_oe); // R9

    AST_MODES_STABLE_RUN: assert property (@(posedge clk) disable iff (!por_n)
        (run_active && !commit) |=> $stable({rmii_mode, led_link_only, mdix_en, adv_abil})); // R7

endmodule

// File: tb/test_strap_latch_top.sv
module test_strap_latch_top;

    localparam int CLK_PERIOD = 40;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_pin_n = 1'b1;
    logic [4:0] pin_addr = 5'd1;
    logic       pin_an_sel = 1'b1, pin_rmii_sel = 1'b0, pin_led_sel = 1'b1, pin_mdix_sel = 1'b1;
    logic       sw_addr_we = 1'b0;
    logic [4:0] sw_addr_wdata = '0;
    logic       strap_pin_oe, isolate, ctl_full_duplex, rmii_mode, led_link_only, mdix_en;
    logic [4:0] phy_addr;
    logic [3:0] adv_abil;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct packed {
        logic [4:0] addr;
        logic       iso;
        logic [3:0] abil;
        logic       fd;
        logic       rmii;
        logic       led;
        logic       mdix;
        logic       oe;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_latch_top i_strap_latch_top (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n),
        .pin_addr(pin_addr), .pin_an_sel(pin_an_sel), .pin_rmii_sel(pin_rmii_sel),
        .pin_led_sel(pin_led_sel), .pin_mdix_sel(pin_mdix_sel),
        .sw_addr_we(sw_addr_we), .sw_addr_wdata(sw_addr_wdata),
        .strap_pin_oe(strap_pin_oe), .phy_addr(phy_addr), .isolate(isolate),
        .adv_abil(adv_abil), .ctl_full_duplex(ctl_full_duplex), .rmii_mode(rmii_mode),
        .led_link_only(led_link_only), .mdix_en(mdix_en)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // expected item computed from the requirements
    function automatic exp_t model(input logic [4:0] a, input logic iso, input logic an,
                                   input logic rm, input logic led, input logic mx);
        exp_t e;
        e.addr = a;   e.iso = iso;
        e.abil = an ? 4'b1111 : 4'b0101;   // R6 order {100F,100H,10F,10H}
        e.fd   = an;  e.rmii = rm; e.led = led; e.mdix = mx; e.oe = 1'b1;
        return e;
    endfunction

    // monitor: pops expected items and compares away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check("R5 phy_addr",        phy_addr,        e.addr);
                check("R4 isolate",         isolate,         e.iso);
                check("R6 adv_abil",        adv_abil,        e.abil);
                check("R6 ctl_full_duplex", ctl_full_duplex, e.fd);
                check("R7 rmii_mode",       rmii_mode,       e.rmii);
                check("R8 led_link_only",   led_link_only,   e.led);
                check("R8 mdix_en",         mdix_en,         e.mdix);
                check("R9 strap_pin_oe",    strap_pin_oe,    e.oe);
            end
        end
    end

    task automatic push(input exp_t e);
        exp_q.push_back(e);
        repeat (2) @(negedge clk);
    endtask

    // hold reset low for exactly n posedges with the given straps
    task automatic reset_pulse(input int n, input logic [4:0] a, input logic an,
                               input logic rm, input logic led, input logic mx,
                               input bit try_write);
        @(negedge clk);
        pin_addr = a; pin_an_sel = an; pin_rmii_sel = rm; pin_led_sel = led; pin_mdix_sel = mx;
        rst_pin_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == n/2) begin
                check("R9 oe low in reset", strap_pin_oe, 0);
                if (try_write) begin sw_addr_we = 1'b1; sw_addr_wdata = 5'd9; end
            end else begin
                sw_addr_we = 1'b0;
            end
        end
        rst_pin_n = 1'b1;
        sw_addr_we = 1'b0;
        @(negedge clk);
        check("R9 oe low right after release", strap_pin_oe, 0);
        // R1: invert straps after release; they must not be taken
        pin_addr = ~a; pin_an_sel = ~an; pin_rmii_sel = ~rm; pin_led_sel = ~led; pin_mdix_sel = ~mx;
        repeat (10) @(negedge clk);
    endtask

    task automatic sw_write(input logic [4:0] v);
        @(negedge clk);
        sw_addr_we = 1'b1; sw_addr_wdata = v;
        @(negedge clk);
        sw_addr_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        repeat (5) @(negedge clk);
        // R3 power-on defaults
        push(model(5'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1));

        // R1 R2 boundary: exactly 25 low cycles commits inverted selects
        reset_pulse(25, 5'h12, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        push(model(5'h12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));

        // R2 R10: 24 cycles is a glitch; write during it is ignored
        reset_pulse(24, 5'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        push(model(5'h12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));

        // R4: strapped address zero sets isolate
        reset_pulse(40, 5'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        push(model(5'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1));

        // R5 R4: software write changes address, isolate stays
        sw_write(5'd7);
        push(model(5'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1));

        // R5: strap commit overrides written address, isolate clears
        reset_pulse(30, 5'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        push(model(5'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1));

        // R4: writing zero does not enter isolate
        sw_write(5'd0);
        push(model(5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1));

        // R1 R6: all-ones address, half duplex only
        reset_pulse(26, 5'h1F, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        push(model(5'h1F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));

        repeat (4) @(negedge clk);
        check("R1 queue drained", exp_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end

endmodule